// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Register

This block gathers three event sources into sticky flags: a periodic tick, an alarm match and an update-finished notice. It also holds one enable bit per source. Any flag whose enable is set pulls an open-drain, active-low interrupt line. The line is modelled as a drive-enable plus a constant-zero data bit, so the board-level pull-up resolves the level.

Software reads the flags as one status byte. The byte carries a summary bit and the three flags, and reading it clears them. The value is frozen when the read strobe goes low and stays constant until the strobe returns high. The clear happens at that rising edge. Events that arrive while a read is open are parked and merged into the flags one cycle after the read ends, so none is lost.

All logic is synchronous to one clock with a synchronous active-low reset. The event inputs are single-cycle pulses from the timing logic around the block.

Top module: `irq_status_reg`

## Requirements
- R1: While reset is low, at the following clock edge `stat_q` becomes 0x00 and `irq_oe` becomes 0.
- R2: The status byte layout is bit 7 = summary (IRQF), bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update flag, and bits 3:0 always read 0.
- R3: An event pulse sets its flag at the next clock edge whatever the state of its enable.
- R4: The summary bit equals (periodic flag AND periodic enable) OR (alarm flag AND alarm enable) OR (update flag AND update enable). `irq_oe` equals the summary bit, and `irq_o` is always 0.
- R5: From the cycle after `stat_rd_n` is sampled low, `stat_q` holds the value captured at that edge until the read ends, even if events arrive meanwhile.
- R6: At the clock edge that samples `stat_rd_n` high after a read, all flags and the summary bit clear.
- R7: An event that arrives while a read is open, including in the cycle the read ends, appears in the flags one cycle after the clear.
- R8: The enables are written with `ctl_wr`, with `ctl_wdata[2]` = periodic, `[1]` = alarm and `[0]` = update. Writing 1 to an enable whose flag is already set raises `irq_oe` at that same edge.
- R9: Reset clears all three enables, so after reset a new event sets its flag but does not raise `irq_oe`.
- R10: Writing an enable back to 0 drops `irq_oe` while the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-finished pulse |
| ctl_wr | input | 1 | Enable register write strobe |
| ctl_wdata | input | 3 | Enable values: [2] periodic, [1] alarm, [0] update |
| stat_rd_n | input | 1 | Active-low status read strobe, level for the whole read |
| stat_q | output | 8 | Status byte |
| irq_oe | output | 1 | Drive-enable of the interrupt line |
| irq_o | output | 1 | Data of the interrupt line, constant 0 |

## Verification
The checker assumes that `stat_rd_n` is synchronous to `clk` and is held low for at least one full cycle per read. It also assumes that reset has been high for two cycles before it relies on the values seen in earlier cycles. The bench changes every input only on the falling clock edge, so each level is seen by exactly one rising edge. It keeps every read at least one cycle long and sends each event as a single-cycle pulse. Events are placed before a read, inside it, and in the cycle the read ends.

// File: rtl/irq_status_pkg.sv
// Package: shared widths and bit positions for the interrupt status register.
// Assumes the status byte is 8 bits with the summary bit on top.
package irq_status_pkg;
    localparam int NSRC    = 3;
    localparam int STAT_W  = 8;
    localparam int PAD_W   = STAT_W - 1 - NSRC;
    localparam int IDX_PER = 2;
    localparam int IDX_ALM = 1;
    localparam int IDX_UPD = 0;
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_evt_capture.sv
// Module: sticky flags with a per-source holding bit for events seen during a read.
// Assumes in_read covers every cycle from read start to read end, and rd_end marks the end cycle.
module irq_evt_capture
    import irq_status_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         in_read,
    input  logic         rd_end,
    output logic [N-1:0] flags
);
    logic [N-1:0] pend;

    for (genvar i = 0; i < N; i++) begin : g_src
        // One flag and one holding bit per source: clear on read end, park during read, merge after.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
                pend[i]  <= 1'b0;
            end else if (rd_end) begin
                flags[i] <= 1'b0;
                pend[i]  <= pend[i] | evt[i];
            end else if (in_read) begin
                pend[i]  <= pend[i] | evt[i];
            end else begin
                flags[i] <= flags[i] | pend[i] | evt[i];
                pend[i]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_rd_track.sv
// Module: tracks the read strobe, snapshots the status byte at read start and
// presents the snapshot for the rest of the read. Assumes rd_n is synchronous to clk.
module irq_rd_track
    import irq_status_pkg::*;
#(
    parameter int W = STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_n,
    input  logic [W-1:0] live,
    output logic         in_read,
    output logic         rd_end,
    output logic [W-1:0] stat_q
);
    logic         rd_now;
    logic         rd_d;
    logic         rd_start;
    logic [W-1:0] snap;

    assign rd_now   = ~rd_n;
    assign rd_start = rd_now & ~rd_d;
    assign rd_end   = ~rd_now & rd_d;
    assign in_read  = rd_now | rd_d;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_d <= 1'b0;
        else        rd_d <= rd_now;
    end

    // Capture the live status byte on the first cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)        snap <= '0;
        else if (rd_start) snap <= live;
    end

    // Show the snapshot while a read is open, the live byte otherwise.
    always_comb begin
        stat_q = rd_d ? snap : live;
    end
endmodule

// File: rtl/irq_gate.sv
// Module: holds the three enables and forms the summary request.
// Assumes flags come from registers, so the summary has a single AND-OR level.
module irq_gate
    import irq_status_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] flags,
    output logic         irqf
);
    logic [N-1:0] en;

    // Enable register, cleared by reset, loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= '0;
        else if (wr) en <= wdata;
    end

    // Summary: any flag whose enable is set.
    always_comb begin
        irqf = |(flags & en);
    end
endmodule

// File: rtl/irq_status_reg.sv
// Module: top of the clear-on-read interrupt status register.
// Assumes single-cycle event pulses and a level read strobe synchronous to clk.
module irq_status_reg
    import irq_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_periodic,
    input  logic             evt_alarm,
    input  logic             evt_update,
    input  logic             ctl_wr,
    input  logic [NSRC-1:0]  ctl_wdata,
    input  logic             stat_rd_n,
    output logic [STAT_W-1:0] stat_q,
    output logic             irq_oe,
    output logic             irq_o
);
    src_vec_t          evt;
    src_vec_t          flags;
    logic              irqf;
    logic              in_read;
    logic              rd_end;
    logic [STAT_W-1:0] live;

    // Gather the event pulses into one vector by source index.
    always_comb begin
        evt          = '0;
        evt[IDX_PER] = evt_periodic;
        evt[IDX_ALM] = evt_alarm;
        evt[IDX_UPD] = evt_update;
    end

    irq_evt_capture #(.N(NSRC)) u_cap (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .in_read(in_read), .rd_end(rd_end), .flags(flags)
    );

    irq_gate #(.N(NSRC)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .flags(flags), .irqf(irqf)
    );

    // Live status byte: summary, flags, zero padding.
    assign live = {irqf, flags, {PAD_W{1'b0}}};

    irq_rd_track #(.W(STAT_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_n(stat_rd_n), .live(live),
        .in_read(in_read), .rd_end(rd_end), .stat_q(stat_q)
    );

    // Open-drain line: drive zero whenever the summary is set.
    assign irq_oe = irqf;
    assign irq_o  = 1'b0;
endmodule

// File: rtl/irq_status_reg_chk.sv
// Checker for irq_status_reg, attached by bind. Observes ports only.
module irq_status_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_periodic,
    input logic       stat_rd_n,
    input logic [7:0] stat_q,
    input logic       irq_oe
);
    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(evt_periodic) &&
         $past(stat_rd_n) && $past(stat_rd_n, 2)) |-> stat_q[6]);

    // R4
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stat_rd_n) && irq_oe) |-> (stat_q[6:4] != 3'b000));

    // R5
    snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(stat_rd_n) && !$past(stat_rd_n, 2))
        |-> $stable(stat_q));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(stat_rd_n) && !$past(stat_rd_n, 2))
        |-> (stat_q == 8'h00 && !irq_oe));
endmodule

bind irq_status_reg irq_status_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_periodic(evt_periodic),
    .stat_rd_n(stat_rd_n), .stat_q(stat_q), .irq_oe(irq_oe)
);

// File: tb/irq_status_reg_test.sv
`timescale 1ns/1ps
module irq_status_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_periodic = 1'b0;
    logic       evt_alarm = 1'b0;
    logic       evt_update = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_wdata = 3'b000;
    logic       stat_rd_n = 1'b1;
    logic [7:0] stat_q;
    logic       irq_oe;
    logic       irq_o;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_reg uut (
        .clk(clk), .rst_n(rst_n), .evt_periodic(evt_periodic), .evt_alarm(evt_alarm),
        .evt_update(evt_update), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat_rd_n(stat_rd_n), .stat_q(stat_q), .irq_oe(irq_oe), .irq_o(irq_o)
    );

    // Pulled-up open-drain line as seen on the board.
    wire irq_line = irq_oe ? irq_o : 1'b1;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic pulse(input int which);
        evt_periodic = (which == 2);
        evt_alarm    = (which == 1);
        evt_update   = (which == 0);
        tick();
        {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    task automatic wr_en(input logic [2:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic clear_read();
        stat_rd_n = 1'b0; tick();
        stat_rd_n = 1'b1; tick(); tick();
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0; tick(); tick();
        chk("R1 stat", stat_q, 8'h00);
        chk("R1 irq_oe", {7'd0, irq_oe}, 8'h00);
        rst_n = 1'b1; tick();
    endtask

    // R3/R2: each flag sets with its enable off, in its own bit.
    task automatic t_poll();
        pulse(2); chk("R3 periodic flag bit6", stat_q, 8'h40);
        chk("R3 no irq", {7'd0, irq_oe}, 8'h00);
        clear_read();
        pulse(1); chk("R2 alarm flag bit5", stat_q, 8'h20);
        clear_read();
        pulse(0); chk("R2 update flag bit4", stat_q, 8'h10);
        clear_read();
    endtask

    // R8/R4/R10: enable an already-set flag, then remove it.
    task automatic t_enable();
        pulse(1);
        wr_en(3'b010);
        chk("R8 irq immediate", {7'd0, irq_oe}, 8'h01);
        chk("R4 stat summary", stat_q, 8'hA0);
        chk("R4 line low", {7'd0, irq_line}, 8'h00);
        wr_en(3'b100);
        chk("R4 unmatched enable", {7'd0, irq_oe}, 8'h00);
        chk("R4 summary off", stat_q, 8'h20);
        wr_en(3'b011);
        chk("R8 re-enable", {7'd0, irq_oe}, 8'h01);
        wr_en(3'b000);
        chk("R10 irq drops", {7'd0, irq_oe}, 8'h00);
        chk("R10 flag kept", stat_q, 8'h20);
        clear_read();
    endtask

    // R5/R6/R7: snapshot, clear on end, parked event.
    task automatic t_read();
        wr_en(3'b001);
        pulse(0);
        stat_rd_n = 1'b0; tick();
        chk("R5 snapshot", stat_q, 8'h90);
        pulse(2);
        chk("R5 stable after event", stat_q, 8'h90);
        tick();
        chk("R5 stable later", stat_q, 8'h90);
        stat_rd_n = 1'b1; tick();
        chk("R6 cleared", stat_q, 8'h00);
        chk("R6 irq released", {7'd0, irq_oe}, 8'h00);
        tick();
        chk("R7 parked event", stat_q, 8'h40);
        clear_read();
        // Event in the very cycle the read ends.
        stat_rd_n = 1'b0; tick();
        stat_rd_n = 1'b1; evt_alarm = 1'b1; tick();
        evt_alarm = 1'b0;
        chk("R7 end-cycle clear", stat_q, 8'h00);
        tick();
        chk("R7 end-cycle event", stat_q, 8'h20);
        clear_read();
    endtask

    // R9: reset clears enables.
    task automatic t_reset_en();
        wr_en(3'b111);
        rst_n = 1'b0; tick();
        rst_n = 1'b1; tick();
        pulse(0);
        chk("R9 flag only", stat_q, 8'h10);
        chk("R9 no irq", {7'd0, irq_oe}, 8'h00);
        clear_read();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_poll();
        t_enable();
        t_read();
        t_reset_en();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule